// File: doc/BRIEF.md
# Grouped Interrupt Status Collector

This block gathers five active-low peripheral request lines and three modem status levels into one byte-wide status word that the CPU can read. Each bit sits at 1 while idle and reads 0 while its peripheral is requesting. The five request lines feed two CPU interrupt lines. The expansion slot, keyboard, serial and network requests share line 0. The SCSI request drives line 1 on its own.

All inputs are asynchronous to the block clock. They pass through a two-stage synchronizer before they reach the status register. Each CPU line is a registered, active-high level that changes only when the state of its group changes. A CPU read captures the status word into a read data register. The read has no side effect on the status word or on the interrupt lines. There is no masking and no priority encoding.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the read data register and the status word are 0xFF, and both CPU lines `irq_o[1:0]` are 0.
- R2: The status bit positions are fixed: bit 0 slot (`src_ni[0]`), bit 1 keyboard (`src_ni[1]`), bit 2 serial (`src_ni[2]`), bit 3 SCSI (`src_ni[3]`), bit 4 network (`src_ni[4]`). Each bit reads 0 while its input is low and 1 while its input is high.
- R3: Bits 5, 6 and 7 follow `modem_i[0]` (data rate select), `modem_i[1]` (data set ready) and `modem_i[2]` (ring indicator) level for level.
- R4: `irq_o[0]` is 1 whenever any of status bits 0, 1, 2 or 4 is 0, no matter which of those sources changed most recently. It is 0 only when all four are 1.
- R5: `irq_o[1]` is 1 exactly when status bit 3 is 0. Group-0 sources never affect `irq_o[1]`, and SCSI never affects `irq_o[0]`.
- R6: An input change reaches the status word on the third rising clock edge after it is applied. The matching CPU line follows on the fourth edge.
- R7: A cycle with `rd_en_i` high loads the current status word into `rd_data_o`, visible after that edge. Otherwise `rd_data_o` holds its value. Reads never change the status word or the CPU lines.
- R8: A CPU line changes only when its group state changes. While the inputs are steady, and while a change inside group 0 keeps at least one group-0 source requesting, `irq_o` shows no transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_ni | input | 5 | Peripheral requests, active low (slot, keyboard, serial, SCSI, network) |
| modem_i | input | 3 | Modem status levels (rate select, data set ready, ring) |
| rd_en_i | input | 1 | CPU read strobe |
| rd_data_o | output | 8 | Status word captured by the last read |
| irq_o | output | 2 | CPU interrupt lines, active high (0: shared group, 1: SCSI) |

## Verification
The bench drives each source low in turn. It confirms that the right status bit clears and the right CPU line rises, so a swapped bit position or a SCSI source wired into group 0 shows up as the wrong bit or the wrong line. It holds two group-0 sources low, releases only one, and counts the line transitions. A design that tracks only the most recently changed source would drop line 0 too early. It measures the edge-exact latency through the synchronizer, which catches a missing or extra stage. It also repeats reads and holds the inputs steady to expose any glitching or any status change caused by a read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned SRC_W       = 5;
  localparam int unsigned MODEM_W     = 3;
  localparam int unsigned STAT_W      = SRC_W + MODEM_W;
  localparam int unsigned NUM_LINES   = 2;
  localparam int unsigned SYNC_STAGES = 2;

  typedef logic [STAT_W-1:0] stat_t;

  // status bit positions; software decodes these
  localparam int unsigned BIT_SLOT = 0;
  localparam int unsigned BIT_KBD  = 1;
  localparam int unsigned BIT_SER  = 2;
  localparam int unsigned BIT_SCSI = 3;
  localparam int unsigned BIT_NET  = 4;
  localparam int unsigned BIT_RATE = 5;
  localparam int unsigned BIT_DSR  = 6;
  localparam int unsigned BIT_RING = 7;

  localparam stat_t STAT_IDLE = '1;

  // which status bits feed each CPU line
  function automatic stat_t line_mask(int unsigned line);
    stat_t m;
    m = '0;
    if (line == 0) begin
      m[BIT_SLOT] = 1'b1;
      m[BIT_KBD]  = 1'b1;
      m[BIT_SER]  = 1'b1;
      m[BIT_NET]  = 1'b1;
    end else begin
      m[BIT_SCSI] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int unsigned        W       = 8,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_agg_stat.sv
module irq_agg_stat
  import irq_agg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t sync_i,
  input  logic  rd_en_i,
  output stat_t stat_o,
  output stat_t rd_data_o
);
  stat_t stat_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= STAT_IDLE;
    else         stat_q <= sync_i;
  end

  // read capture; no side effect on stat_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= STAT_IDLE;
    else if (rd_en_i) rd_q <= stat_q;
  end

  assign stat_o    = stat_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/irq_agg_line.sv
module irq_agg_line
  import irq_agg_pkg::*;
#(
  parameter stat_t MASK = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  stat_t stat_i,
  output logic  line_o
);
  logic req, line_q;

  // any masked bit at 0 is a pending request
  assign req = |(~stat_i & MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            line_q <= 1'b0;
    else if (req != line_q) line_q <= req;
  end

  assign line_o = line_q;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SRC_W-1:0]   src_ni,
  input  logic [MODEM_W-1:0] modem_i,
  input  logic               rd_en_i,
  output logic [STAT_W-1:0]  rd_data_o,
  output logic [NUM_LINES-1:0] irq_o
);
  stat_t raw, sync, stat_w, rd_w;

  assign raw = {modem_i, src_ni};

  irq_agg_sync #(
    .W      (STAT_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(STAT_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (sync)
  );

  irq_agg_stat u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync),
    .rd_en_i  (rd_en_i),
    .stat_o   (stat_w),
    .rd_data_o(rd_w)
  );

  for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_line
    irq_agg_line #(
      .MASK(line_mask(g))
    ) u_line (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .stat_i(stat_w),
      .line_o(irq_o[g])
    );
  end

  assign rd_data_o = rd_w;
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [4:0] src_ni,
  input logic [2:0] modem_i,
  input logic       rd_en_i,
  input logic [7:0] rd_data_o,
  input logic [1:0] irq_o,
  input logic [7:0] stat_q
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd3) |-> (stat_q == $past({modem_i, src_ni}, 3)));

  p_grp0_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o[0] == $past(!(stat_q[0] && stat_q[1] && stat_q[2] && stat_q[4]))));

  p_scsi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o[1] == $past(!stat_q[3])));

  p_steady_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(stat_q) |=> $stable(irq_o));

  p_rd_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (rd_data_o == $past(stat_q)));

  p_rd_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind irq_status_agg irq_status_agg_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_ni   (src_ni),
  .modem_i  (modem_i),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o),
  .stat_q   (stat_w)
);

// File: tb/tb_irq_status_agg.sv
`timescale 1ns/1ps
module tb_irq_status_agg;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] src_ni = 5'h1f;
  logic [2:0] modem_i = 3'h7;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [1:0] irq_o;

  int checks = 0;
  int errors = 0;
  int irq_edges = 0;
  logic [1:0] irq_prev = 2'b00;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_status_agg dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_ni(src_ni), .modem_i(modem_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni && irq_o != irq_prev) irq_edges++;
    irq_prev <= irq_o;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_i);
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk_i); rd_en_i = 1'b1;
    @(negedge clk_i); rd_en_i = 1'b0; v = rd_data_o;
  endtask

  function automatic logic [1:0] exp_irq(logic [4:0] s);
    return {~s[3], ~(s[0] & s[1] & s[2] & s[4])};
  endfunction

  task automatic t_reset();
    chk("R1 rd_data", rd_data_o, 8'hff);
    chk("R1 irq", {6'd0, irq_o}, 8'h00);
  endtask

  task automatic t_each_source();
    logic [7:0] v;
    for (int b = 0; b < 5; b++) begin
      @(negedge clk_i); src_ni = 5'h1f & ~(5'h1 << b);
      settle(); do_read(v);
      chk("R2 bit position", v, {3'h7, src_ni});
      chk((b == 3) ? "R5 scsi line" : "R4 group line", {6'd0, irq_o}, {6'd0, exp_irq(src_ni)});
    end
    @(negedge clk_i); src_ni = 5'h1f; settle();
    chk("R4 all idle", {6'd0, irq_o}, 8'h00);
  endtask

  task automatic t_modem();
    logic [7:0] v;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk_i); modem_i = m[2:0];
      settle(); do_read(v);
      chk("R3 modem bits", v, {m[2:0], 5'h1f});
      chk("R3 modem no irq", {6'd0, irq_o}, 8'h00);
    end
    @(negedge clk_i); modem_i = 3'h7; settle();
  endtask

  task automatic t_latency();
    @(negedge clk_i); rd_en_i = 1'b1; src_ni = 5'h1d; // keyboard
    @(negedge clk_i); @(negedge clk_i); @(negedge clk_i);
    chk("R6 status after 3 edges (rd shows old)", rd_data_o, 8'hff);
    chk("R6 irq before 4th edge", {6'd0, irq_o}, 8'h00);
    @(negedge clk_i);
    chk("R6 rd after 4th edge", rd_data_o, 8'hfd);
    chk("R6 irq after 4th edge", {6'd0, irq_o}, 8'h01);
    rd_en_i = 1'b0; src_ni = 5'h1f; settle();
  endtask

  task automatic t_group_hold();
    int e0;
    @(negedge clk_i); src_ni = 5'h1e;          // slot
    @(negedge clk_i); src_ni = 5'h0e;          // plus network
    settle(); e0 = irq_edges;
    @(negedge clk_i); src_ni = 5'h0f;          // slot released, network still low
    settle();
    chk("R4 line 0 held by remaining source", {6'd0, irq_o}, 8'h01);
    chk("R8 no transition within group", irq_edges[7:0], e0[7:0]);
    @(negedge clk_i); src_ni = 5'h07;          // scsi too
    settle();
    chk("R5 both lines", {6'd0, irq_o}, 8'h03);
    @(negedge clk_i); src_ni = 5'h17;          // network released
    settle();
    chk("R5 scsi isolated", {6'd0, irq_o}, 8'h02);
    @(negedge clk_i); src_ni = 5'h1f; settle();
    chk("R4 R5 released", {6'd0, irq_o}, 8'h00);
  endtask

  task automatic t_steady_and_reads();
    int e0;
    logic [7:0] v;
    @(negedge clk_i); src_ni = 5'h1b; settle();  // serial
    e0 = irq_edges;
    for (int i = 0; i < 5; i++) begin
      do_read(v);
      chk("R7 repeated read", v, 8'hfb);
    end
    repeat (10) @(negedge clk_i);
    chk("R8 steady inputs no toggles", irq_edges[7:0], e0[7:0]);
    chk("R7 read leaves irq", {6'd0, irq_o}, 8'h01);
    @(negedge clk_i); src_ni = 5'h1f; settle();
    chk("R7 rd_data holds without strobe", rd_data_o, 8'hfb);
    do_read(v);
    chk("R7 fresh read", v, 8'hff);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    settle();
    t_reset();
    t_each_source();
    t_modem();
    t_latency();
    t_group_hold();
    t_steady_and_reads();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule